// File: doc/BRIEF.md
# High-Bandwidth Isochronous Transaction Sequencer

This block runs the bus transactions that one isochronous endpoint owns in a single micro-frame of a USB host-style controller. A start pulse presents a descriptor record with these fields: an active flag, a direction flag, a multiplier (transactions per micro-frame), a maximum packet size and a 12-bit transaction length. The block then issues packet requests to a packet engine, one at a time. Each request waits for the engine's done/count/error response before the next one is issued.

For OUT, the length is cut into pieces no larger than the packet size. Each request carries the byte count to send. For IN, each request carries the allowance for that packet. The block adds up the received counts and flags babble when a packet is larger than its allowance. At the end it pulses done and presents the updated length, three status bits and a cleared active flag for write-back.

Top module: `iso_hb_seq`

## Requirements
- R1: After reset, `done_o`, `pkt_start_o` and `wb_act_o` are 0 and `wb_sts_o` is 0.
- R2: A start with `act_i`=0 issues no packet request. `done_o` is high in the cycle after the start is sampled, with `wb_len_o` equal to `len_i` and `wb_sts_o`=0.
- R3: A start with `act_i`=1 and `mult_i`=0 issues no packet request. Done follows in the next cycle with `wb_sts_o[2]` (multiplier error) set and `wb_len_o` equal to `len_i`.
- R4: For OUT (`dir_in_i`=0), each request's `pkt_size_o` is the smaller of the maximum packet size and the remaining length. After each packet the remaining length drops by the maximum packet size, saturating at 0. `wb_len_o` reports the remaining length.
- R5: For OUT, the sequence ends as soon as the remaining length reaches 0, even if multiplier transactions are left. A zero starting length issues no request, and no OUT request has size 0.
- R6: No more than `mult_i` packet requests are issued per start.
- R7: For IN (`dir_in_i`=1), `pkt_size_o` is the allowance, which is the smaller of the maximum packet size and the length minus the bytes received so far. All `mult_i` transactions run, and `wb_len_o` reports the sum of received counts.
- R8: An IN response count above its allowance sets `wb_sts_o[0]` (babble) and ends the sequence with no further request. The written-back length is then unspecified.
- R9: An IN total below the maximum packet size (short packet) raises no status bit.
- R10: A response with `pkt_err_i`=1 sets `wb_sts_o[1]` (transaction error) and ends the sequence. The written-back length is then unspecified.
- R11: `done_o` is a one-cycle pulse in the cycle after the final response is sampled. `wb_act_o` is 1 from the cycle after an accepted start with transactions until done, and 0 while `done_o` is high.
- R12: `start_i` is ignored while a sequence runs, and `pkt_done_i` is ignored in the cycle a request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; descriptor fields valid with it |
| act_i | input | 1 | Descriptor active flag |
| dir_in_i | input | 1 | 1 = IN, 0 = OUT |
| mult_i | input | 2 | Transactions per micro-frame |
| max_pkt_i | input | 11 | Maximum packet size in bytes (1..1024) |
| len_i | input | 12 | Transaction length in bytes |
| pkt_start_o | output | 1 | One-cycle packet request |
| pkt_size_o | output | 11 | OUT bytes to send / IN allowance |
| pkt_in_o | output | 1 | Direction of the request |
| pkt_done_i | input | 1 | Engine response strobe |
| pkt_cnt_i | input | 11 | Bytes moved by the packet |
| pkt_err_i | input | 1 | Engine transaction error |
| done_o | output | 1 | Sequence complete pulse |
| wb_act_o | output | 1 | Active flag for write-back |
| wb_len_o | output | 12 | Length for write-back |
| wb_sts_o | output | 3 | Status: [0] babble, [1] transaction error, [2] multiplier error |

## Verification
A request appears in the cycle after the start is sampled, or in the cycle after a response that is not final. Done appears in the cycle after the start for skipped sequences, or after the final response otherwise. Each write-back value is valid while done is high. The bench drives on falling edges and samples on falling edges. It stamps the cycle of every start and response and requires each done exactly one cycle after the last stamp. Expected request sizes and results are queued by the driver and popped by the engine model and the done monitor as they appear.

// File: rtl/iso_hb_pkg.sv
package iso_hb_pkg;
  localparam int LEN_W  = 12;
  localparam int PKT_W  = 11;
  localparam int MULT_W = 2;
  localparam int STS_W  = 3;
  localparam int STS_BABBLE = 0;
  localparam int STS_XERR   = 1;
  localparam int STS_MULT   = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_FIN} seq_st_e;
endpackage

// File: rtl/iso_hb_len.sv
module iso_hb_len #(
  parameter int LEN_W = iso_hb_pkg::LEN_W,
  parameter int PKT_W = iso_hb_pkg::PKT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic             skip_i,
  input  logic             dir_in_i,
  input  logic [PKT_W-1:0] max_pkt_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [PKT_W-1:0] cnt_i,
  output logic             dir_o,
  output logic [PKT_W-1:0] size_o,
  output logic             babble_o,
  output logic             rem_zero_nxt_o,
  output logic [LEN_W-1:0] wb_len_o
);
  logic             dir_q;
  logic [LEN_W-1:0] max_q, len0_q, rem_q, acc_q;
  logic [LEN_W-1:0] cnt_ext, size_full, rem_nxt;

  assign cnt_ext   = LEN_W'(cnt_i);
  assign size_full = (rem_q < max_q) ? rem_q : max_q;
  assign size_o    = size_full[PKT_W-1:0];
  assign babble_o  = dir_q && (cnt_ext > size_full);
  assign dir_o     = dir_q;

  always_comb begin
    if (dir_q) rem_nxt = (rem_q > cnt_ext) ? rem_q - cnt_ext : '0;
    else       rem_nxt = (rem_q > max_q)   ? rem_q - max_q   : '0;
  end
  assign rem_zero_nxt_o = (rem_nxt == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= 1'b0;
      max_q  <= '0;
      len0_q <= '0;
      rem_q  <= '0;
      acc_q  <= '0;
    end else if (load_i) begin
      dir_q  <= dir_in_i;
      max_q  <= LEN_W'(max_pkt_i);
      len0_q <= len_i;
      rem_q  <= len_i;
      acc_q  <= '0;
    end else if (step_i && !babble_o) begin
      rem_q <= rem_nxt;
      if (dir_q) acc_q <= acc_q + cnt_ext;
    end
  end

  assign wb_len_o = skip_i ? len0_q : (dir_q ? acc_q : rem_q);

  // IN: received plus allowance left always equals the original length
  assert_in_sum_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_q |-> ({1'b0, acc_q} + {1'b0, rem_q} == {1'b0, len0_q}));
  assert_out_rem_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !dir_q && !load_i) |=> (rem_q <= $past(rem_q)));
endmodule

// File: rtl/iso_hb_ctrl.sv
module iso_hb_ctrl
  import iso_hb_pkg::*;
#(
  parameter int MULT_W = iso_hb_pkg::MULT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              act_i,
  input  logic              dir_in_i,
  input  logic              len_zero_i,
  input  logic [MULT_W-1:0] mult_i,
  input  logic              dir_q_i,
  input  logic              pkt_done_i,
  input  logic              babble_i,
  input  logic              err_i,
  input  logic              rem_zero_nxt_i,
  output logic              load_o,
  output logic              step_o,
  output logic              skip_o,
  output logic              pkt_start_o,
  output logic              done_o,
  output logic              act_o
);
  seq_st_e           st_q, st_d;
  logic [MULT_W-1:0] mult_q, cnt_q;
  logic              skip_q, act_q, skip_now, stop_now;

  assign load_o   = (st_q == ST_IDLE) && start_i;
  assign step_o   = (st_q == ST_WAIT) && pkt_done_i;
  assign skip_now = !act_i || (mult_i == '0);
  assign stop_now = babble_i || err_i || ((cnt_q + 1'b1) == mult_q) ||
                    (!dir_q_i && rem_zero_nxt_i);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start_i)
                  st_d = (skip_now || (!dir_in_i && len_zero_i)) ? ST_FIN : ST_ISSUE;
      ST_ISSUE: st_d = ST_WAIT;
      ST_WAIT:  if (pkt_done_i) st_d = stop_now ? ST_FIN : ST_ISSUE;
      ST_FIN:   st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      mult_q <= '0;
      cnt_q  <= '0;
      skip_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      act_q <= (st_d == ST_ISSUE) || (st_d == ST_WAIT);
      if (load_o) begin
        mult_q <= mult_i;
        cnt_q  <= '0;
        skip_q <= skip_now;
      end else if (step_o) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign skip_o      = skip_q;
  assign pkt_start_o = (st_q == ST_ISSUE);
  assign done_o      = (st_q == ST_FIN);
  assign act_o       = act_q;

  assert_mult_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ISSUE) |-> (cnt_q < mult_q));
  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_inactive_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !act_o);
  assert_req_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_start_o |=> !pkt_start_o);
endmodule

// File: rtl/iso_hb_seq.sv
module iso_hb_seq
  import iso_hb_pkg::*;
#(
  parameter int LEN_W  = iso_hb_pkg::LEN_W,
  parameter int PKT_W  = iso_hb_pkg::PKT_W,
  parameter int MULT_W = iso_hb_pkg::MULT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              act_i,
  input  logic              dir_in_i,
  input  logic [MULT_W-1:0] mult_i,
  input  logic [PKT_W-1:0]  max_pkt_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              pkt_start_o,
  output logic [PKT_W-1:0]  pkt_size_o,
  output logic              pkt_in_o,
  input  logic              pkt_done_i,
  input  logic [PKT_W-1:0]  pkt_cnt_i,
  input  logic              pkt_err_i,
  output logic              done_o,
  output logic              wb_act_o,
  output logic [LEN_W-1:0]  wb_len_o,
  output logic [STS_W-1:0]  wb_sts_o
);
  logic load, step, skip, dir_q, babble, rem_zero_nxt;
  logic [STS_W-1:0] sts_q;

  iso_hb_ctrl #(.MULT_W(MULT_W)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .act_i, .dir_in_i,
    .len_zero_i(len_i == '0), .mult_i, .dir_q_i(dir_q), .pkt_done_i,
    .babble_i(babble), .err_i(pkt_err_i), .rem_zero_nxt_i(rem_zero_nxt),
    .load_o(load), .step_o(step), .skip_o(skip), .pkt_start_o,
    .done_o, .act_o(wb_act_o)
  );

  iso_hb_len #(.LEN_W(LEN_W), .PKT_W(PKT_W)) u_len (
    .clk_i, .rst_ni, .load_i(load), .step_i(step), .skip_i(skip),
    .dir_in_i, .max_pkt_i, .len_i, .cnt_i(pkt_cnt_i),
    .dir_o(dir_q), .size_o(pkt_size_o), .babble_o(babble),
    .rem_zero_nxt_o(rem_zero_nxt), .wb_len_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0;
    end else if (load) begin
      sts_q <= '0;
      sts_q[STS_MULT] <= act_i && (mult_i == '0);
    end else if (step) begin
      if (babble)    sts_q[STS_BABBLE] <= 1'b1;
      if (pkt_err_i) sts_q[STS_XERR]   <= 1'b1;
    end
  end

  assign wb_sts_o = sts_q;
  assign pkt_in_o = dir_q;

  assert_babble_ends_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && babble) |=> (done_o && wb_sts_o[STS_BABBLE]));
  assert_err_ends_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && pkt_err_i) |=> (done_o && wb_sts_o[STS_XERR]));
  assert_out_nonzero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_start_o && !pkt_in_o) |-> (pkt_size_o != '0));
  assert_skip_no_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && (!act_i || mult_i == '0)) |=> (done_o && !pkt_start_o));
endmodule

// File: tb/iso_hb_seq_tb_top.sv
module iso_hb_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, act = 1'b0, dir_in = 1'b0;
  logic [1:0]  mult = '0;
  logic [10:0] max_pkt = '0;
  logic [11:0] len = '0;
  logic        pkt_start, pkt_in, pkt_done = 1'b0, pkt_err = 1'b0;
  logic [10:0] pkt_size, pkt_cnt = '0;
  logic        done, wb_act;
  logic [11:0] wb_len;
  logic [2:0]  wb_sts;

  int checks = 0, errors = 0, cyc = 0, last_evt = 0, done_seen = 0;
  bit spurious = 1'b0;
  int exp_size_q[$], resp_cnt_q[$], resp_err_q[$];
  int exp_len_q[$], exp_sts_q[$], exp_chk_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  iso_hb_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .act_i(act), .dir_in_i(dir_in),
    .mult_i(mult), .max_pkt_i(max_pkt), .len_i(len),
    .pkt_start_o(pkt_start), .pkt_size_o(pkt_size), .pkt_in_o(pkt_in),
    .pkt_done_i(pkt_done), .pkt_cnt_i(pkt_cnt), .pkt_err_i(pkt_err),
    .done_o(done), .wb_act_o(wb_act), .wb_len_o(wb_len), .wb_sts_o(wb_sts)
  );

  task automatic chk(input bit ok, input string tag, input int act_v, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act_v, exp_v);
    end
  endtask

  // engine model: pops expected request sizes, answers with queued counts
  initial begin
    forever begin
      @(negedge clk);
      pkt_done = 1'b0;
      pkt_err  = 1'b0;
      if (pkt_start) begin
        if (exp_size_q.size() == 0) begin
          chk(1'b0, "R6 unexpected request", pkt_size, -1);
        end else begin
          chk(pkt_size == exp_size_q.pop_front(), "R4/R7 request size", pkt_size, -1);
          chk(wb_act == 1'b1, "R11 active while running", wb_act, 1);
        end
        if (spurious) begin  // R12: strobe in the issue cycle must be ignored
          pkt_done = 1'b1;
          pkt_cnt  = 11'd2047;
        end
        @(negedge clk);
        pkt_cnt  = (resp_cnt_q.size() != 0) ? 11'(resp_cnt_q.pop_front()) : '0;
        pkt_err  = (resp_err_q.size() != 0) ? 1'(resp_err_q.pop_front()) : 1'b0;
        pkt_done = 1'b1;
        last_evt = cyc;
      end
    end
  end

  // done monitor
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        done_seen++;
        chk(cyc == last_evt + 1, "R11 done timing", cyc, last_evt + 1);
        chk(wb_act == 1'b0, "R11 active cleared at done", wb_act, 0);
        chk(exp_size_q.size() == 0, "R5/R6 requests missing", exp_size_q.size(), 0);
        if (exp_len_q.size() == 0) begin
          chk(1'b0, "R11 unexpected done", 1, 0);
        end else begin
          int el, es, ec;
          el = exp_len_q.pop_front();
          es = exp_sts_q.pop_front();
          ec = exp_chk_q.pop_front();
          chk(wb_sts == 3'(es), "R8/R9/R10 status", wb_sts, es);
          if (ec != 0) chk(wb_len == 12'(el), "R2/R4/R7 written length", wb_len, el);
        end
      end
    end
  end

  // driver: computes expectations from the requirements, then starts the block
  task automatic run_case(input bit a, input bit d, input int m, input int mx, input int l,
                          input int rx0, input int rx1, input int rx2, input int err_at,
                          input bit busy_poke);
    int rx[3];
    int rem, acc, sts, target;
    bit chk_len;
    rx[0] = rx0; rx[1] = rx1; rx[2] = rx2;
    rem = l; acc = 0; sts = 0; chk_len = 1'b1;
    if (!a) begin
      acc = l;
    end else if (m == 0) begin
      sts = 4; acc = l;  // R3
    end else if (!d) begin
      for (int i = 0; i < m && rem > 0; i++) begin
        exp_size_q.push_back(rem < mx ? rem : mx);
        resp_cnt_q.push_back(rem < mx ? rem : mx);
        resp_err_q.push_back(i == err_at);
        rem = (rem > mx) ? rem - mx : 0;
        if (i == err_at) begin sts = 2; chk_len = 1'b0; break; end
      end
      acc = rem;
    end else begin
      for (int i = 0; i < m; i++) begin
        int allow;
        allow = rem < mx ? rem : mx;
        exp_size_q.push_back(allow);
        resp_cnt_q.push_back(rx[i]);
        resp_err_q.push_back(i == err_at);
        if (i == err_at) begin sts = 2; chk_len = 1'b0; break; end
        if (rx[i] > allow) begin sts = 1; chk_len = 1'b0; break; end
        acc += rx[i];
        rem -= rx[i];
      end
    end
    exp_len_q.push_back(acc);
    exp_sts_q.push_back(sts);
    exp_chk_q.push_back(chk_len);
    target = done_seen + 1;
    @(negedge clk);
    act = a; dir_in = d; mult = 2'(m); max_pkt = 11'(mx); len = 12'(l);
    start = 1'b1;
    last_evt = cyc;
    @(negedge clk);
    start = 1'b0;
    if (busy_poke) begin  // R12: a start while running must be ignored
      @(negedge clk);
      act = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (done_seen < target) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(done_seen == target, "R12 extra done", done_seen, target);
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(done == 1'b0 && pkt_start == 1'b0, "R1 reset outputs", {done, pkt_start}, 0);
    chk(wb_act == 1'b0 && wb_sts == 3'd0, "R1 reset status", {wb_act, wb_sts}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_case(0, 0, 3, 1024, 777, 0, 0, 0, -1, 0);         // R2 inactive
    run_case(1, 1, 0, 512, 300, 0, 0, 0, -1, 0);          // R3 multiplier zero
    run_case(1, 0, 3, 1024, 3000, 0, 0, 0, -1, 0);        // R4 full OUT
    run_case(1, 0, 3, 1024, 1500, 0, 0, 0, -1, 0);        // R5 early end
    run_case(1, 0, 2, 1024, 4000, 0, 0, 0, -1, 0);        // R6 multiplier caps
    run_case(1, 0, 2, 256, 0, 0, 0, 0, -1, 0);            // R5 zero length
    run_case(1, 0, 1, 1024, 1024, 0, 0, 0, -1, 0);        // R4 exact boundary
    run_case(1, 1, 3, 1024, 3072, 1024, 1024, 1000, -1, 0); // R7 IN sum
    run_case(1, 1, 2, 512, 1000, 100, 50, 0, -1, 0);      // R9 short packet
    run_case(1, 1, 3, 1024, 1500, 1024, 500, 0, -1, 0);   // R8 babble on second
    run_case(1, 1, 3, 64, 1000, 65, 0, 0, -1, 0);         // R8 babble vs packet size
    run_case(1, 1, 3, 256, 800, 0, 0, 0, 0, 0);           // R10 engine error
    spurious = 1'b1;
    run_case(1, 1, 3, 256, 600, 256, 256, 88, -1, 1);     // R12 ignored strobes
    spurious = 1'b0;
    run_case(1, 0, 3, 512, 1100, 0, 0, 0, -1, 1);         // R12 OUT while poked
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule